// File: doc/BRIEF.md
# Wide Accumulator MAC Bank

This block is a bank of wide accumulators for a SIMD multiply-accumulate datapath. Each accumulator has 32 signed 48-bit lanes, so one accumulator is three times as wide as a 512-bit vector. A MAC port takes two 512-bit operand vectors, each holding 32 signed 16-bit lanes. It multiplies them lane by lane and adds the products into the selected accumulator. A clear variant overwrites the accumulator with the products instead. The operands are registered on entry, the products one stage later, and the accumulator is read, updated and written back in a single stage. Back-to-back operations on the same accumulator therefore chain at one per cycle, and each result lands two cycles after issue.

Accumulated values leave the bank only through a narrowing readout port. A readout picks an accumulator and a shift amount. Each lane is rounded, shifted right arithmetically and saturated, to 16 bits for a full vector, or to 32 bits for one half of the lanes, so that two steps give a full-width result. The same port can copy one accumulator into another, which is used to spill and restore accumulators. A sticky flag records any saturation seen since reset.

Top module: `wacc_bank`

## Requirements
- R1: After reset all four accumulators read as zero in every lane, `rd_valid_o` is 0 and `ovf_o` is 0.
- R2: A MAC (`mac_clear_i`=0) adds to each 48-bit lane `n` of accumulator `mac_acc_i` the signed product of the 16-bit lanes `n` of `mac_a_i` and `mac_b_i`. Lane `n` occupies bits [16n+15:16n] of each operand. The product is sign-extended before the add.
- R3: A MAC sampled at clock edge k updates its accumulator at edge k+2. A readout sampled at edge k+2 sees the value from before the update. A readout sampled at edge k+3 sees the updated value.
- R4: MACs issued on consecutive cycles to the same accumulator all accumulate, with none of them lost.
- R5: With `mac_clear_i`=1 the accumulator lanes become the products alone, and the previous contents are discarded.
- R6: `rd_op_i`=0 is a 16-bit pack. Each lane `v` of accumulator `rd_src_i` becomes `(v + 2^(s-1)) >>> s`, with nothing added when s=0. The result is clamped to [-32768, 32767] and placed at `rd_data_o` bits [16n+15:16n]. `rd_valid_o` is 1 in the cycle after the request.
- R7: `rd_op_i`=1 packs lanes 0..15 and `rd_op_i`=2 packs lanes 16..31. Both use the same rounding and shift, clamp to the signed 32-bit range, and place half-lane j at bits [32j+31:32j].
- R8: A shift amount above 47 is treated as 47.
- R9: `ovf_o` is set when any lane clamps during a readout. It stays set until reset.
- R10: `rd_op_i`=3 copies accumulator `rd_src_i` into `rd_dst_i` at the sampling edge. If a MAC writeback to the same destination lands at that edge, the MAC result is kept and the copy is dropped.
- R11: After a copy, or a cycle with no readout, `rd_valid_o` is 0 and `rd_data_o` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mac_valid_i | input | 1 | Issue a MAC this cycle |
| mac_clear_i | input | 1 | Overwrite instead of accumulate |
| mac_acc_i | input | 2 | Target accumulator |
| mac_a_i | input | 512 | Operand A, 32 x signed 16-bit |
| mac_b_i | input | 512 | Operand B, 32 x signed 16-bit |
| rd_valid_i | input | 1 | Issue a readout or copy |
| rd_op_i | input | 2 | 0 pack16, 1 pack32 low half, 2 pack32 high half, 3 copy |
| rd_src_i | input | 2 | Source accumulator |
| rd_dst_i | input | 2 | Copy destination |
| rd_shift_i | input | 6 | Right shift amount |
| rd_valid_o | output | 1 | Readout data valid |
| rd_data_o | output | 512 | Narrowed readout vector |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
The MAC writeback and a readout or copy on the same accumulator can fall on the same clock edge. The bench provokes this by issuing a readout or copy exactly two cycles after a MAC to that accumulator. A readout on that edge must return the value from before the update, and the next readout must return the updated value. A copy into the accumulator being written must be dropped, so that the accumulator ends up holding only the MAC product.

// File: rtl/wacc_pkg.sv
`timescale 1ns/1ps
package wacc_pkg;
  typedef enum logic [1:0] {
    RD_PACK16    = 2'd0,
    RD_PACK32_LO = 2'd1,
    RD_PACK32_HI = 2'd2,
    RD_MOVE      = 2'd3
  } rd_op_e;
endpackage

// File: rtl/wacc_mac_pipe.sv
`timescale 1ns/1ps
module wacc_mac_pipe #(
  parameter int LANES = 32,
  parameter int OP_W  = 16,
  parameter int IDX_W = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic                      clear_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [LANES*OP_W-1:0]     a_i,
  input  logic [LANES*OP_W-1:0]     b_i,
  output logic                      wb_valid_o,
  output logic                      wb_clear_o,
  output logic [IDX_W-1:0]          wb_idx_o,
  output logic [LANES*2*OP_W-1:0]   wb_prod_o
);
  localparam int PROD_W = 2 * OP_W;
  localparam int VEC_W  = LANES * OP_W;

  logic             s1_valid, s1_clear;
  logic [IDX_W-1:0] s1_idx;
  logic [VEC_W-1:0] s1_a, s1_b;
  logic [LANES*PROD_W-1:0] prod_d;

  // operand stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_clear <= 1'b0;
      s1_idx   <= '0;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_valid <= valid_i;
      s1_clear <= clear_i;
      s1_idx   <= idx_i;
      if (valid_i) begin
        s1_a <= a_i;
        s1_b <= b_i;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mul
    logic signed [OP_W-1:0]   a_l, b_l;
    logic signed [PROD_W-1:0] p_l;
    assign a_l = s1_a[l*OP_W +: OP_W];
    assign b_l = s1_b[l*OP_W +: OP_W];
    assign p_l = a_l * b_l;
    assign prod_d[l*PROD_W +: PROD_W] = p_l;
  end

  // product stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o <= 1'b0;
      wb_clear_o <= 1'b0;
      wb_idx_o   <= '0;
      wb_prod_o  <= '0;
    end else begin
      wb_valid_o <= s1_valid;
      wb_clear_o <= s1_clear;
      wb_idx_o   <= s1_idx;
      if (s1_valid) wb_prod_o <= prod_d;
    end
  end
endmodule

// File: rtl/wacc_narrow.sv
`timescale 1ns/1ps
module wacc_narrow #(
  parameter int ACC_W = 48,
  parameter int OUT_W = 16,
  parameter int SH_W  = 6
) (
  input  logic [ACC_W-1:0] val_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [OUT_W-1:0] res_o,
  output logic             sat_o
);
  localparam logic signed [ACC_W:0] MAX_V =
    {{(ACC_W+2-OUT_W){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W:0] MIN_V = ~MAX_V;

  logic signed [ACC_W:0] ext, rnd, sum, shd;
  logic        [ACC_W:0] one_sh;
  logic                  hi, lo;

  assign ext    = {val_i[ACC_W-1], val_i};
  // half of one LSB at the output scale; zero when shift is zero
  assign one_sh = {{ACC_W{1'b0}}, 1'b1} << shift_i;
  assign rnd    = signed'(one_sh >> 1);
  assign sum    = ext + rnd;
  assign shd    = sum >>> shift_i;
  assign hi     = shd > MAX_V;
  assign lo     = shd < MIN_V;
  assign sat_o  = hi | lo;
  assign res_o  = hi ? MAX_V[OUT_W-1:0] : (lo ? MIN_V[OUT_W-1:0] : shd[OUT_W-1:0]);
endmodule

// File: rtl/wacc_bank.sv
`timescale 1ns/1ps
module wacc_bank
  import wacc_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int LANES   = 32,
  parameter int OP_W    = 16,
  parameter int ACC_W   = 48,
  parameter int OUT_W   = 16,
  parameter int SH_W    = 6
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 mac_valid_i,
  input  logic                                 mac_clear_i,
  input  logic [$clog2(NUM_ACC)-1:0]           mac_acc_i,
  input  logic [LANES*OP_W-1:0]                mac_a_i,
  input  logic [LANES*OP_W-1:0]                mac_b_i,
  input  logic                                 rd_valid_i,
  input  logic [1:0]                           rd_op_i,
  input  logic [$clog2(NUM_ACC)-1:0]           rd_src_i,
  input  logic [$clog2(NUM_ACC)-1:0]           rd_dst_i,
  input  logic [SH_W-1:0]                      rd_shift_i,
  output logic                                 rd_valid_o,
  output logic [LANES*OUT_W-1:0]               rd_data_o,
  output logic                                 ovf_o
);
  localparam int IDX_W    = $clog2(NUM_ACC);
  localparam int PROD_W   = 2 * OP_W;
  localparam int ACC_BITS = LANES * ACC_W;
  localparam int HALF     = LANES / 2;
  localparam int WIDE_W   = 2 * OUT_W;
  localparam int OUT_BITS = LANES * OUT_W;
  localparam logic [SH_W-1:0] SH_MAX = SH_W'(ACC_W - 1);

  logic [ACC_BITS-1:0] acc_q [NUM_ACC];

  logic                     wb_valid, wb_clear;
  logic [IDX_W-1:0]         wb_idx;
  logic [LANES*PROD_W-1:0]  wb_prod;
  logic [ACC_BITS-1:0]      acc_cur, acc_new;

  wacc_mac_pipe #(.LANES(LANES), .OP_W(OP_W), .IDX_W(IDX_W)) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (mac_valid_i),
    .clear_i    (mac_clear_i),
    .idx_i      (mac_acc_i),
    .a_i        (mac_a_i),
    .b_i        (mac_b_i),
    .wb_valid_o (wb_valid),
    .wb_clear_o (wb_clear),
    .wb_idx_o   (wb_idx),
    .wb_prod_o  (wb_prod)
  );

  // read-modify-write stage: read the register itself, so the next MAC sees this write
  assign acc_cur = acc_q[wb_idx];
  for (genvar l = 0; l < LANES; l++) begin : g_add
    logic [ACC_W-1:0] base_l, prod_l;
    assign base_l = wb_clear ? '0 : acc_cur[l*ACC_W +: ACC_W];
    assign prod_l = {{(ACC_W-PROD_W){wb_prod[l*PROD_W+PROD_W-1]}}, wb_prod[l*PROD_W +: PROD_W]};
    assign acc_new[l*ACC_W +: ACC_W] = base_l + prod_l;
  end

  rd_op_e rd_op;
  logic   mv_go, pack_go;
  assign rd_op   = rd_op_e'(rd_op_i);
  assign pack_go = rd_valid_i && (rd_op != RD_MOVE);
  assign mv_go   = rd_valid_i && (rd_op == RD_MOVE) && !(wb_valid && (wb_idx == rd_dst_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < NUM_ACC; a++) acc_q[a] <= '0;
    end else begin
      for (int a = 0; a < NUM_ACC; a++) begin
        if (wb_valid && (wb_idx == IDX_W'(a)))      acc_q[a] <= acc_new;
        else if (mv_go && (rd_dst_i == IDX_W'(a)))  acc_q[a] <= acc_q[rd_src_i];
      end
    end
  end

  // narrowing readout
  logic [ACC_BITS-1:0] src_acc;
  logic [SH_W-1:0]     sh_eff;
  logic [OUT_BITS-1:0] n16, n32, rd_data_d;
  logic [LANES-1:0]    sat16;
  logic [HALF-1:0]     sat32;
  logic                sat_any;

  assign src_acc = acc_q[rd_src_i];
  assign sh_eff  = (rd_shift_i > SH_MAX) ? SH_MAX : rd_shift_i;

  for (genvar l = 0; l < LANES; l++) begin : g_n16
    wacc_narrow #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_n (
      .val_i   (src_acc[l*ACC_W +: ACC_W]),
      .shift_i (sh_eff),
      .res_o   (n16[l*OUT_W +: OUT_W]),
      .sat_o   (sat16[l])
    );
  end

  for (genvar j = 0; j < HALF; j++) begin : g_n32
    logic [ACC_W-1:0] lane_j;
    assign lane_j = (rd_op == RD_PACK32_HI) ? src_acc[(j+HALF)*ACC_W +: ACC_W]
                                            : src_acc[j*ACC_W +: ACC_W];
    wacc_narrow #(.ACC_W(ACC_W), .OUT_W(WIDE_W), .SH_W(SH_W)) u_n (
      .val_i   (lane_j),
      .shift_i (sh_eff),
      .res_o   (n32[j*WIDE_W +: WIDE_W]),
      .sat_o   (sat32[j])
    );
  end

  assign rd_data_d = (rd_op == RD_PACK16) ? n16 : n32;
  assign sat_any   = (rd_op == RD_PACK16) ? |sat16 : |sat32;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      ovf_o      <= 1'b0;
    end else begin
      rd_valid_o <= pack_go;
      if (pack_go) rd_data_o <= rd_data_d;
      if (pack_go && sat_any) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wacc_bank_chk.sv
`timescale 1ns/1ps
module wacc_bank_chk
  import wacc_pkg::*;
#(
  parameter int OUT_BITS = 512
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                mac_valid_i,
  input logic                rd_valid_i,
  input logic [1:0]          rd_op_i,
  input logic                wb_valid_i,
  input logic                rd_valid_o,
  input logic [OUT_BITS-1:0] rd_data_o,
  input logic                ovf_o
);
  // R3
  mac_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i == $past(mac_valid_i, 2));

  // R6
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o == $past(rd_valid_i && (rd_op_i != RD_MOVE)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R9
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(rd_valid_i && (rd_op_i != RD_MOVE)));

  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> $stable(rd_data_o));
endmodule

bind wacc_bank wacc_bank_chk #(.OUT_BITS(LANES*OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mac_valid_i (mac_valid_i),
  .rd_valid_i  (rd_valid_i),
  .rd_op_i     (rd_op_i),
  .wb_valid_i  (wb_valid),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .ovf_o       (ovf_o)
);

// File: tb/wacc_bank_tb_top.sv
`timescale 1ns/1ps
module wacc_bank_tb_top;
  localparam int NACC  = 4;
  localparam int LANES = 32;
  localparam int OP_W  = 16;
  localparam int OUT_W = 16;
  localparam int VW    = LANES * OP_W;
  localparam int OW    = LANES * OUT_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mac_valid = 1'b0, mac_clear = 1'b0;
  logic [1:0]    mac_acc = '0;
  logic [VW-1:0] mac_a = '0, mac_b = '0;
  logic          rd_valid = 1'b0;
  logic [1:0]    rd_op = '0, rd_src = '0, rd_dst = '0;
  logic [5:0]    rd_shift = '0;
  logic          rd_valid_o, ovf_o;
  logic [OW-1:0] rd_data_o;

  always #2.5 clk = ~clk;

  wacc_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .mac_valid_i(mac_valid), .mac_clear_i(mac_clear), .mac_acc_i(mac_acc),
    .mac_a_i(mac_a), .mac_b_i(mac_b),
    .rd_valid_i(rd_valid), .rd_op_i(rd_op), .rd_src_i(rd_src), .rd_dst_i(rd_dst),
    .rd_shift_i(rd_shift),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .ovf_o(ovf_o)
  );

  longint        macc [NACC][LANES];
  int            checks = 0, fails = 0;
  bit            done = 1'b0;
  logic [OW-1:0] rq;
  logic          rv;

  function automatic longint nref(longint v, int sh, int w);
    int s = (sh > 47) ? 47 : sh;
    longint r  = (s == 0) ? 0 : (longint'(1) <<< (s - 1));
    longint t  = (v + r) >>> s;
    longint mx = (longint'(1) <<< (w - 1)) - 1;
    longint mn = -mx - 1;
    if (t > mx) t = mx;
    if (t < mn) t = mn;
    return t;
  endfunction

  function automatic logic [OW-1:0] exp_rd(int op, int src, int sh);
    logic [OW-1:0] e = '0;
    if (op == 0) begin
      for (int l = 0; l < LANES; l++) e[l*16 +: 16] = 16'(nref(macc[src][l], sh, 16));
    end else begin
      for (int j = 0; j < LANES/2; j++)
        e[j*32 +: 32] = 32'(nref(macc[src][(op == 2) ? j + LANES/2 : j], sh, 32));
    end
    return e;
  endfunction

  function automatic logic [VW-1:0] vfull(int seed);
    logic [VW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*16 +: 16] = 16'(seed*40503 + l*9973 + 12345);
    return v;
  endfunction

  function automatic logic [VW-1:0] vramp(int k, int base);
    logic [VW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*16 +: 16] = 16'(l*k - base);
    return v;
  endfunction

  task automatic chk_vec(string req, logic [OW-1:0] act, logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // tasks start just after a falling edge and end on the next one
  task automatic mac(bit clr, int idx, logic [VW-1:0] a, logic [VW-1:0] b);
    mac_valid = 1'b1; mac_clear = clr; mac_acc = 2'(idx); mac_a = a; mac_b = b;
    for (int l = 0; l < LANES; l++) begin
      longint p = longint'($signed(a[l*16 +: 16])) * longint'($signed(b[l*16 +: 16]));
      longint v = (clr ? 0 : macc[idx][l]) + p;
      macc[idx][l] = (v <<< 16) >>> 16;
    end
    @(negedge clk);
    mac_valid = 1'b0; mac_clear = 1'b0;
  endtask

  task automatic rd(int op, int src, int dst, int sh);
    rd_valid = 1'b1; rd_op = 2'(op); rd_src = 2'(src); rd_dst = 2'(dst); rd_shift = 6'(sh);
    @(negedge clk);
    rq = rd_data_o; rv = rd_valid_o;
    rd_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_bit("R1 valid in reset", rd_valid_o, 1'b0);
    chk_bit("R1 ovf in reset", ovf_o, 1'b0);
    rst_n = 1'b1;
    idle(1);
    for (int a = 0; a < NACC; a++) begin
      rd(0, a, 0, 0);
      chk_vec("R1 zero acc", rq, '0);
    end
    chk_bit("R6 rd_valid_o after pack", rv, 1'b1);
  endtask

  task automatic t_mac_basic();
    mac(1'b0, 1, vfull(3), vfull(11));
    idle(2);
    rd(1, 1, 0, 0);
    chk_vec("R2 R7 low half", rq, exp_rd(1, 1, 0));
    rd(2, 1, 0, 0);
    chk_vec("R2 R7 high half", rq, exp_rd(2, 1, 0));
  endtask

  task automatic t_latency();
    logic [OW-1:0] old_v = exp_rd(0, 2, 0);
    logic [OW-1:0] new_v;
    mac(1'b1, 2, vramp(1, -1), vramp(0, -3));
    new_v = exp_rd(0, 2, 0);
    rd(0, 2, 0, 0);
    chk_vec("R3 edge k+1 old", rq, old_v);
    rd(0, 2, 0, 0);
    chk_vec("R3 edge k+2 old", rq, old_v);
    rd(0, 2, 0, 0);
    chk_vec("R3 edge k+3 new", rq, new_v);
  endtask

  task automatic t_b2b();
    mac(1'b1, 0, vfull(5), vfull(6));
    mac(1'b0, 0, vfull(7), vfull(8));
    mac(1'b0, 0, vfull(9), vfull(10));
    mac(1'b0, 0, vfull(12), vfull(13));
    idle(2);
    rd(1, 0, 0, 8);
    chk_vec("R4 chain low", rq, exp_rd(1, 0, 8));
    rd(2, 0, 0, 8);
    chk_vec("R4 chain high", rq, exp_rd(2, 0, 8));
  endtask

  task automatic t_clear();
    mac(1'b1, 1, vramp(37, 600), vramp(3, 45));
    idle(2);
    rd(0, 1, 0, 0);
    chk_vec("R5 clear-multiply", rq, exp_rd(0, 1, 0));
  endtask

  task automatic t_round();
    mac(1'b1, 3, vramp(37, 600), vramp(5, 77));
    idle(2);
    rd(0, 3, 0, 1);
    chk_vec("R6 shift 1", rq, exp_rd(0, 3, 1));
    rd(0, 3, 0, 3);
    chk_vec("R6 shift 3", rq, exp_rd(0, 3, 3));
    rd(0, 3, 0, 4);
    chk_vec("R6 shift 4", rq, exp_rd(0, 3, 4));
  endtask

  task automatic t_hold_move();
    logic [OW-1:0] last;
    rd(1, 0, 0, 8);
    last = rq;
    rd(3, 0, 1, 0);
    for (int l = 0; l < LANES; l++) macc[1][l] = macc[0][l];
    chk_bit("R11 valid low after copy", rv, 1'b0);
    chk_vec("R11 data held", rq, last);
    idle(1);
    rd(1, 1, 0, 8);
    chk_vec("R10 copy low", rq, exp_rd(1, 1, 8));
    rd(2, 0, 0, 8);
    chk_vec("R10 source intact", rq, exp_rd(2, 0, 8));
    mac(1'b1, 3, vramp(2, 20), vramp(3, 40));
    idle(1);
    rd(3, 1, 3, 0);  // lands on the writeback edge; copy is dropped
    idle(2);
    rd(0, 3, 0, 0);
    chk_vec("R10 MAC wins collision", rq, exp_rd(0, 3, 0));
  endtask

  task automatic t_sat();
    logic [VW-1:0] bsat;
    for (int l = 0; l < LANES; l++) bsat[l*16 +: 16] = (l % 2) ? 16'(-32767) : 16'(32767);
    chk_bit("R9 ovf clear before clamp", ovf_o, 1'b0);
    mac(1'b1, 2, {LANES{16'sd32767}}, bsat);
    idle(2);
    rd(0, 2, 0, 0);
    chk_vec("R9 clamp 16", rq, exp_rd(0, 2, 0));
    chk_bit("R9 ovf set", ovf_o, 1'b1);
    mac(1'b0, 2, {LANES{16'sd32767}}, bsat);
    mac(1'b0, 2, {LANES{16'sd32767}}, bsat);
    idle(2);
    rd(1, 2, 0, 0);
    chk_vec("R9 R7 clamp 32", rq, exp_rd(1, 2, 0));
    rd(0, 3, 0, 0);
    chk_bit("R9 ovf sticky", ovf_o, 1'b1);
  endtask

  task automatic t_shift_clamp();
    rd(1, 2, 0, 63);
    chk_vec("R8 shift 63 as 47", rq, exp_rd(1, 2, 47));
    rd(2, 2, 0, 50);
    chk_vec("R8 shift 50 as 47", rq, exp_rd(2, 2, 47));
  endtask

  initial begin
    for (int a = 0; a < NACC; a++)
      for (int l = 0; l < LANES; l++) macc[a][l] = 0;
    idle(3);
    t_reset();
    t_mac_basic();
    t_latency();
    t_b2b();
    t_clear();
    t_round();
    t_hold_move();
    t_sat();
    t_shift_clamp();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule